// File: doc/BRIEF.md
# Reservation Monitor for Linked Load / Conditional Store

This block holds one reservation so that software can build indivisible read-modify-write sequences (test-and-set, compare-and-swap) without locking the bus. A linked load records the doubleword it touched and raises a single link flag. A later conditional store is allowed to write memory only if that flag is still up and the store targets the same doubleword. Three things drop the flag:

- a write by another agent to the reserved doubleword, seen on the snoop inputs;
- an exception return;
- the conditional store itself, whether it succeeded or not.

Requests arrive on a valid/ready channel and are accepted on a clock edge where `req_valid` and `req_ready` are both high. Each accepted request produces exactly one response, one cycle later, on a valid/ready response channel. The response carries the store result and an alignment-error flag. The response register holds a single entry. While it holds an unconsumed response, `req_ready` is low. The response payload stays frozen until `rsp_ready` takes it.

The memory write strobe is plain, not handshaked. It pulses for exactly one cycle, in the cycle the matching response first appears. The snoop inputs and the exception-return input are also plain, with no handshake.

Top module: `llsc_monitor`

## Requirements
- R1: After reset, `rsp_valid` and `mem_we` are low, `req_ready` is high, and the link flag is clear, so a conditional store issued straight after reset fails.
- R2: `req_op` = 0 is a linked load and `req_op` = 1 is a conditional store. After an aligned linked load, an aligned conditional store to the same doubleword returns `rsp_ok`=1. It also pulses `mem_we` with that store's address and data, in the cycle after acceptance.
- R3: A conditional store fails (`rsp_ok`=0, no `mem_we` pulse) if the link flag is clear, or if address bits [ADDR_W-1:3] differ from the reserved doubleword.
- R4: A snoop write whose address bits [ADDR_W-1:3] equal the reserved doubleword clears the link flag; bits [2:0] are ignored. A snoop to another doubleword leaves the flag alone.
- R5: An exception-return pulse clears the link flag.
- R6: Every aligned conditional store clears the link flag, so a second store without a new linked load fails.
- R7: A new aligned linked load replaces the reserved doubleword and sets the flag again.
- R8: If a matching snoop write or an exception return coincides with the acceptance of a conditional store, the store fails and does not write.
- R9: A request whose address bits [2:0] are nonzero returns `rsp_err`=1 and `rsp_ok`=0 with no write, and leaves the reservation as it was.
- R10: `req_ready` is low while a response is pending and not accepted. A stalled response keeps its payload. `mem_we` never stays high for two cycles in a row.
- R11: A linked load accepted in the same cycle as an exception return or a matching snoop still leaves the link flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_op | input | 1 | 0 linked load, 1 conditional store |
| req_addr | input | ADDR_W | Byte address of the access |
| req_data | input | DATA_W | Store data |
| snoop_valid | input | 1 | Another agent writes memory this cycle |
| snoop_addr | input | ADDR_W | Address of that write |
| eret | input | 1 | Exception return this cycle |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed |
| rsp_ok | output | 1 | Conditional store succeeded |
| rsp_err | output | 1 | Misaligned address error |
| mem_we | output | 1 | Memory write strobe |
| mem_waddr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |

## Verification
The link flag and the reserved doubleword are both hidden, so the ports can only reveal them through the next conditional store. The bench reads every `rsp_ok` and `mem_we` as a probe of that hidden state.

A flag that fails to clear, or a stale reservation tag, shows up as a wrong success and a spurious write one cycle after the probing store is accepted. A flag that clears too eagerly shows up as a lost write in that same cycle. Same-cycle collisions between stores, loads, snoops and exception returns are driven on purpose, because a wrong priority between them is otherwise invisible.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic {
    OP_LINK_LOAD  = 1'b0,
    OP_COND_STORE = 1'b1
  } llsc_op_e;
endpackage

// File: rtl/llsc_align_chk.sv
module llsc_align_chk #(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              misaligned_o
);
  generate
    if (OFFS_W == 0) begin : g_byte
      logic unused_addr;
      assign unused_addr  = ^addr_i;
      assign misaligned_o = 1'b0;
    end else begin : g_wide
      logic unused_hi;
      assign unused_hi    = ^addr_i[ADDR_W-1:OFFS_W];
      assign misaligned_o = |addr_i[OFFS_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/llsc_resv.sv
module llsc_resv #(
  parameter int TAG_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic [TAG_W-1:0] set_tag_i,
  input  logic             consume_i,
  input  logic             eret_i,
  input  logic             snp_valid_i,
  input  logic [TAG_W-1:0] snp_tag_i,
  output logic             link_o,
  output logic [TAG_W-1:0] tag_o,
  output logic             kill_o
);
  logic             link_q;
  logic [TAG_W-1:0] tag_q;

  // Clearing events seen this cycle against the current reservation.
  assign kill_o = link_q && (eret_i || (snp_valid_i && (snp_tag_i == tag_q)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_q <= 1'b0;
      tag_q  <= '0;
    end else if (set_i) begin
      link_q <= 1'b1;
      tag_q  <= set_tag_i;
    end else if (consume_i || kill_o) begin
      link_q <= 1'b0;
    end
  end

  assign link_o = link_q;
  assign tag_o  = tag_q;

  p_eret_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eret_i && !set_i) |=> !link_q);
  p_store_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (consume_i && !set_i) |=> !link_q);
  p_load_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> (link_q && tag_q == $past(set_tag_i)));
endmodule

// File: rtl/llsc_resp.sv
module llsc_resp #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              ok_i,
  input  logic              err_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              space_o,
  input  logic              rsp_ready_i,
  output logic              rsp_valid_o,
  output logic              rsp_ok_o,
  output logic              rsp_err_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_waddr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  assign space_o = !rsp_valid_o || rsp_ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_ok_o    <= 1'b0;
      rsp_err_o   <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_waddr_o <= '0;
      mem_wdata_o <= '0;
    end else begin
      mem_we_o <= 1'b0;
      if (load_i) begin
        rsp_valid_o <= 1'b1;
        rsp_ok_o    <= ok_i;
        rsp_err_o   <= err_i;
        mem_we_o    <= we_i;
        mem_waddr_o <= addr_i;
        mem_wdata_o <= data_i;
      end else if (rsp_ready_i) begin
        rsp_valid_o <= 1'b0;
      end
    end
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |=>
      (rsp_valid_o && $stable(rsp_ok_o) && $stable(rsp_err_o)));
  p_we_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> !mem_we_o);
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              eret,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_ok,
  output logic              rsp_err,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int OFFS_W = $clog2(DATA_W / 8);
  localparam int TAG_W  = ADDR_W - OFFS_W;

  logic             accept, misaligned, is_store, link, kill;
  logic             ld_set, st_consume, st_ok;
  logic [TAG_W-1:0] req_tag, snp_tag, resv_tag;
  logic             unused_snoop_offs;

  assign accept   = req_valid && req_ready;
  assign is_store = (llsc_op_e'(req_op) == OP_COND_STORE);
  assign req_tag  = req_addr[ADDR_W-1:OFFS_W];
  assign snp_tag  = snoop_addr[ADDR_W-1:OFFS_W];
  assign unused_snoop_offs = ^snoop_addr[OFFS_W-1:0];

  llsc_align_chk #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_align (
    .addr_i       (req_addr),
    .misaligned_o (misaligned)
  );

  assign ld_set     = accept && !is_store && !misaligned;
  assign st_consume = accept &&  is_store && !misaligned;
  assign st_ok      = st_consume && link && (req_tag == resv_tag) && !kill;

  llsc_resv #(.TAG_W(TAG_W)) u_resv (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_i       (ld_set),
    .set_tag_i   (req_tag),
    .consume_i   (st_consume),
    .eret_i      (eret),
    .snp_valid_i (snoop_valid),
    .snp_tag_i   (snp_tag),
    .link_o      (link),
    .tag_o       (resv_tag),
    .kill_o      (kill)
  );

  llsc_resp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_resp (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (accept),
    .ok_i        (st_ok),
    .err_i       (misaligned),
    .we_i        (st_ok),
    .addr_i      (req_addr),
    .data_i      (req_data),
    .space_o     (req_ready),
    .rsp_ready_i (rsp_ready),
    .rsp_valid_o (rsp_valid),
    .rsp_ok_o    (rsp_ok),
    .rsp_err_o   (rsp_err),
    .mem_we_o    (mem_we),
    .mem_waddr_o (mem_waddr),
    .mem_wdata_o (mem_wdata)
  );

  p_misalign_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && misaligned) |=> (!mem_we && rsp_err));
  p_nolink_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_store && !link) |=> !mem_we);
  p_collision_fails_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_store && kill) |=> (!mem_we && !rsp_ok));
  p_stall_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

// File: tb/tb_llsc_monitor.sv
module tb_llsc_monitor;
  localparam int AW = 32;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_op = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          snoop_valid = 1'b0, eret = 1'b0, rsp_ready = 1'b1;
  logic [AW-1:0] snoop_addr = '0;
  logic          req_ready, rsp_valid, rsp_ok, rsp_err, mem_we;
  logic [AW-1:0] mem_waddr;
  logic [DW-1:0] mem_wdata;

  always #5 clk = ~clk;

  llsc_monitor #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .eret(eret),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ok(rsp_ok),
    .rsp_err(rsp_err), .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  typedef struct {
    logic          ok;
    logic          err;
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    string         req;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0, n_fail = 0, we_cnt = 0, cycles = 0;
  logic [AW-1:0] we_addr;
  logic [DW-1:0] we_data;
  logic          m_link = 1'b0;
  logic [AW-4:0] m_tag = '0;

  task automatic chk(input bit cond, input string r, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  // Driver: issue one request, optionally with a same-cycle snoop / eret.
  task automatic send(input logic op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic snp, input logic [AW-1:0] sa, input logic er,
                      input string r);
    exp_t e;
    logic mis, hit;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    snoop_valid = snp; snoop_addr = sa; eret = er;
    while (!req_ready) @(negedge clk);
    mis = (a[2:0] != 3'b000);
    hit = m_link && (er || (snp && sa[AW-1:3] == m_tag));
    e.ok   = !mis && op && m_link && (a[AW-1:3] == m_tag) && !hit;
    e.err  = mis;
    e.we   = e.ok;
    e.addr = a;
    e.data = d;
    e.req  = r;
    q.push_back(e);
    if (!mis && !op) begin m_link = 1'b1; m_tag = a[AW-1:3]; end
    else if (!mis && op) m_link = 1'b0;
    else if (hit) m_link = 1'b0;
    @(negedge clk);
    req_valid = 1'b0; snoop_valid = 1'b0; eret = 1'b0;
  endtask

  task automatic side(input logic snp, input logic [AW-1:0] sa, input logic er);
    @(negedge clk);
    snoop_valid = snp; snoop_addr = sa; eret = er;
    if (m_link && (er || (snp && sa[AW-1:3] == m_tag))) m_link = 1'b0;
    @(negedge clk);
    snoop_valid = 1'b0; eret = 1'b0;
  endtask

  task automatic ll(input logic [AW-1:0] a, input string r);
    send(1'b0, a, '0, 1'b0, '0, 1'b0, r);
  endtask

  task automatic sc(input logic [AW-1:0] a, input logic [DW-1:0] d, input string r);
    send(1'b1, a, d, 1'b0, '0, 1'b0, r);
  endtask

  // Monitor: scoreboard compare at each response handshake.
  always @(negedge clk) begin
    exp_t e;
    #2;
    if (rst_n) begin
      if (mem_we) begin we_cnt++; we_addr = mem_waddr; we_data = mem_wdata; end
      if (rsp_valid && rsp_ready) begin
        if (q.size() == 0) begin
          chk(1'b0, "R10", "unexpected response", 1, 0);
        end else begin
          e = q.pop_front();
          chk(rsp_ok == e.ok, e.req, "rsp_ok", rsp_ok, e.ok);
          chk(rsp_err == e.err, e.req, "rsp_err", rsp_err, e.err);
          chk(we_cnt == (e.we ? 1 : 0), e.req, "write pulses", we_cnt, e.we);
          if (e.we) begin
            chk(we_addr == e.addr, e.req, "mem_waddr", we_addr, e.addr);
            chk(we_data == e.data, e.req, "mem_wdata", we_data, e.data);
          end
          we_cnt = 0;
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      chk(1'b0, "watchdog", "timeout", cycles, 0);
      finish_run();
    end
  end

  localparam logic [AW-1:0] A = 32'h0000_1040;
  localparam logic [AW-1:0] B = 32'h0000_2080;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    // R1 reset state
    chk(rsp_valid == 1'b0, "R1", "rsp_valid", rsp_valid, 0);
    chk(mem_we == 1'b0, "R1", "mem_we", mem_we, 0);
    chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
    sc(A, 64'h11, "R1");
    // R2 basic success, R6 second store fails
    ll(A, "R2");
    sc(A, 64'hDEAD_BEEF_0123_4567, "R2");
    sc(A, 64'h22, "R6");
    // R3 wrong doubleword
    ll(A, "R3");
    sc(B, 64'h33, "R3");
    sc(A, 64'h34, "R6");
    // R4 matching snoop (offset bits ignored) vs neighbouring doubleword
    ll(A, "R4");
    side(1'b1, A + 32'd5, 1'b0);
    sc(A, 64'h44, "R4");
    ll(A, "R4");
    side(1'b1, A + 32'd8, 1'b0);
    sc(A, 64'h45, "R4");
    // R5 exception return
    ll(A, "R5");
    side(1'b0, '0, 1'b1);
    sc(A, 64'h55, "R5");
    // R7 replacement
    ll(A, "R7");
    ll(B, "R7");
    sc(A, 64'h77, "R7");
    ll(A, "R7");
    ll(B, "R7");
    sc(B, 64'h78, "R7");
    // R8 same-cycle collisions
    ll(A, "R8");
    send(1'b1, A, 64'h88, 1'b1, A + 32'd3, 1'b0, "R8");
    ll(A, "R8");
    send(1'b1, A, 64'h89, 1'b0, '0, 1'b1, "R8");
    // R9 misaligned requests leave the reservation untouched
    ll(A, "R9");
    sc(A + 32'd3, 64'h99, "R9");
    sc(A, 64'h9A, "R9");
    ll(A + 32'd4, "R9");
    sc(A, 64'h9B, "R9");
    // R11 linked load wins against same-cycle eret / matching snoop
    send(1'b0, A, '0, 1'b0, '0, 1'b1, "R11");
    sc(A, 64'hB1, "R11");
    ll(A, "R11");
    send(1'b0, A, '0, 1'b1, A, 1'b0, "R11");
    sc(A, 64'hB2, "R11");
    // R10 back-pressure
    @(negedge clk); rsp_ready = 1'b0;
    ll(B, "R10");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #2;
      chk(rsp_valid == 1'b1, "R10", "rsp_valid held", rsp_valid, 1);
      chk(req_ready == 1'b0, "R10", "req_ready while stalled", req_ready, 0);
    end
    @(negedge clk); rsp_ready = 1'b1;
    sc(B, 64'hC0FFEE, "R10");
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R10", "pending responses", q.size(), 0);
    finish_run();
  end
endmodule